// File: doc/BRIEF.md
# Miss Reload Buffer with Store Merging

This block parks data-cache misses while their cache blocks are fetched from the next memory level. It has eight slots. Each slot holds a block address, a few attribute bits, a 32-byte line and a 32-bit mask that marks which bytes are valid. A miss takes the lowest free slot through the allocate port. A store miss writes its bytes into the line when it allocates. A later store miss to the same block goes through the merge port and writes into the slot that already exists, without starting a new coherency request. Returned fill data lands only in bytes that no store has written.

A slot becomes ready for the cache reload port once every byte is valid and its coherency condition is met. Load slots need only their bytes. A store slot also waits for the coherency-done pulse of the store that allocated it, unless that store was marked as not needing coherency. If stores cover the whole line, no fill is needed. The reload port presents the lowest-numbered ready slot. The slot is freed when the consumer accepts it, and the allocator can reuse it on the next cycle.

Top module: `mrb_top`

## Requirements
- R1: An allocate request (cacheable load, cache-inhibited load or store) takes the lowest-numbered free slot, and `alloc_idx` reports that slot in the same cycle.
- R2: When all slots are occupied, `alloc_stall` is high while `alloc_valid` is high, and no slot changes. A slot freed by a reload handshake is free for allocation on the next cycle.
- R3: A store allocation writes the bytes selected by `alloc_be` (bit b selects byte b, data bits 8b+7..8b) into the line and marks them valid. A load allocation marks no byte valid.
- R4: A merge request whose block address equals that of an occupied store-allocated slot raises `mrg_hit` in the same cycle and writes its enabled bytes into that slot. A merge request that matches only load slots (cacheable or cache-inhibited), or no slot, gives `mrg_hit` low and changes nothing.
- R5: Fill data for a slot is written only into bytes whose valid bit is clear, and it then marks all bytes valid. Bytes written by stores keep their store data.
- R6: When a merge and a fill reach the same slot in one cycle, the merged bytes win over the fill bytes.
- R7: A store slot that needs coherency is not presented for reload until the coherency-done pulse for that slot arrives, even when all its bytes are valid. Merged stores do not need a pulse of their own.
- R8: A load slot is presented for reload once fill data arrives, with no coherency pulse.
- R9: If stores (allocating plus merged) write all 32 bytes, the slot becomes ready with no fill.
- R10: A store slot allocated with `alloc_nocoh` set becomes ready as soon as all its bytes are valid, with no coherency pulse.
- R11: When several slots are ready, the lowest-numbered one is presented. `rld_valid` stays high until `rld_ready`. The handshake frees that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_addr | input | BLK_W | Block address of the miss |
| alloc_store | input | 1 | Miss is a store |
| alloc_inhibit | input | 1 | Miss is cache-inhibited |
| alloc_nocoh | input | 1 | Store needs no coherency action |
| alloc_be | input | 32 | Store byte enables |
| alloc_data | input | 256 | Store data |
| alloc_stall | output | 1 | Request rejected, no free slot |
| alloc_idx | output | IW | Slot taken by the request |
| mrg_valid | input | 1 | Merge-store request |
| mrg_addr | input | BLK_W | Block address of the merging store |
| mrg_be | input | 32 | Merge byte enables |
| mrg_data | input | 256 | Merge data |
| mrg_hit | output | 1 | Merge accepted by a store slot |
| fill_valid | input | 1 | Fill data valid |
| fill_idx | input | IW | Slot being filled |
| fill_data | input | 256 | Full returned line |
| coh_valid | input | 1 | Coherency done pulse |
| coh_idx | input | IW | Slot whose coherency action finished |
| rld_valid | output | 1 | A slot is ready for reload |
| rld_idx | output | IW | Slot being presented |
| rld_addr | output | BLK_W | Block address of that slot |
| rld_data | output | 256 | Line of that slot |
| rld_inhibit | output | 1 | Slot came from a cache-inhibited access |
| rld_ready | input | 1 | Consumer accepts the reload |

## Verification
The bench sweeps a single store byte over all 32 positions and checks that every other byte comes from the fill. A fill that overwrites store bytes, or an off-by-one lane, would show up as a wrong byte. It sends a merge and a fill to one slot in the same cycle, which catches a design that lets the fill win. It also sends merges aimed at load slots, and a design that matches on address alone would then corrupt a load line. It fills the buffer completely, checks the stall, and frees two slots in reverse readiness order. This exposes a wrong priority, a slot that is not reused, or a stalled request that overwrites a busy slot. Store slots are held back until their coherency pulse, and slots that are fully stored or marked not-coherent are released early. A design that confuses the two cases releases a slot too early or never releases it.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
    localparam int LINE_BYTES = 32;
    localparam int LINE_W     = LINE_BYTES * 8;

    typedef logic [LINE_BYTES-1:0] bmask_t;
    typedef logic [LINE_W-1:0]     line_t;

    typedef struct packed {
        logic store;
        logic inhibit;
        logic nocoh;
    } attr_t;

    // per-byte choose: take b where sel is set, else a
    function automatic line_t byte_pick(line_t a, line_t b, bmask_t sel);
        line_t r;
        for (int i = 0; i < LINE_BYTES; i++)
            r[i*8 +: 8] = sel[i] ? b[i*8 +: 8] : a[i*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/mrb_pick.sv
module mrb_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mrb_entry.sv
module mrb_entry
    import mrb_pkg::*;
#(
    parameter int BLK_W = 27
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_we,
    input  logic [BLK_W-1:0] alloc_addr,
    input  attr_t            alloc_attr,
    input  bmask_t           alloc_be,
    input  line_t            alloc_data,
    input  logic             mrg_we,
    input  bmask_t           mrg_be,
    input  line_t            mrg_data,
    input  logic             fill_we,
    input  line_t            fill_data,
    input  logic             coh_we,
    input  logic             free_we,
    output logic             valid,
    output logic [BLK_W-1:0] addr,
    output attr_t            attr,
    output line_t            data,
    output logic             coh_ok,
    output logic             ready
);
    bmask_t mask;
    bmask_t mrg_sel;
    bmask_t fill_sel;
    line_t  upd_data;

    always_comb begin
        mrg_sel  = mrg_we ? mrg_be : '0;
        fill_sel = fill_we ? ~(mask | mrg_sel) : '0;
        upd_data = byte_pick(byte_pick(data, fill_data, fill_sel), mrg_data, mrg_sel);
    end

    assign ready = valid && (&mask) && coh_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            addr   <= '0;
            attr   <= '0;
            mask   <= '0;
            data   <= '0;
            coh_ok <= 1'b0;
        end else if (alloc_we) begin
            valid  <= 1'b1;
            addr   <= alloc_addr;
            attr   <= alloc_attr;
            mask   <= alloc_be;
            data   <= byte_pick('0, alloc_data, alloc_be);
            coh_ok <= !alloc_attr.store || alloc_attr.nocoh;
        end else if (free_we) begin
            valid  <= 1'b0;
            mask   <= '0;
            coh_ok <= 1'b0;
        end else if (valid) begin
            data <= upd_data;
            mask <= mask | mrg_sel | fill_sel;
            if (coh_we)
                coh_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/mrb_top.sv
module mrb_top
    import mrb_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int BLK_W   = 27,
    parameter int IW      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_valid,
    input  logic [BLK_W-1:0]      alloc_addr,
    input  logic                  alloc_store,
    input  logic                  alloc_inhibit,
    input  logic                  alloc_nocoh,
    input  logic [LINE_BYTES-1:0] alloc_be,
    input  logic [LINE_W-1:0]     alloc_data,
    output logic                  alloc_stall,
    output logic [IW-1:0]         alloc_idx,
    input  logic                  mrg_valid,
    input  logic [BLK_W-1:0]      mrg_addr,
    input  logic [LINE_BYTES-1:0] mrg_be,
    input  logic [LINE_W-1:0]     mrg_data,
    output logic                  mrg_hit,
    input  logic                  fill_valid,
    input  logic [IW-1:0]         fill_idx,
    input  logic [LINE_W-1:0]     fill_data,
    input  logic                  coh_valid,
    input  logic [IW-1:0]         coh_idx,
    output logic                  rld_valid,
    output logic [IW-1:0]         rld_idx,
    output logic [BLK_W-1:0]      rld_addr,
    output logic [LINE_W-1:0]     rld_data,
    output logic                  rld_inhibit,
    input  logic                  rld_ready
);
    logic [NUM_ENT-1:0] valid_vec, ready_vec, coh_vec, free_vec, match_vec;
    logic [BLK_W-1:0]   addr_arr [NUM_ENT];
    line_t              data_arr [NUM_ENT];
    attr_t              attr_arr [NUM_ENT];

    logic          free_found, mrg_found, rld_fire, alloc_fire;
    logic [IW-1:0] mrg_idx;
    attr_t         new_attr;
    bmask_t        new_be;

    assign new_attr   = '{store: alloc_store, inhibit: alloc_inhibit, nocoh: alloc_nocoh};
    assign new_be     = alloc_store ? alloc_be : '0;
    assign free_vec   = ~valid_vec;
    assign rld_fire   = rld_valid && rld_ready;
    assign alloc_fire = alloc_valid && free_found;
    assign alloc_stall = alloc_valid && !free_found;
    assign mrg_hit    = mrg_valid && mrg_found;

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++)
            match_vec[i] = valid_vec[i] && attr_arr[i].store &&
                           (addr_arr[i] == mrg_addr) &&
                           !(rld_fire && (rld_idx == IW'(i)));
    end

    mrb_pick #(.N(NUM_ENT), .IW(IW)) u_pick_free (
        .req(free_vec), .found(free_found), .idx(alloc_idx));
    mrb_pick #(.N(NUM_ENT), .IW(IW)) u_pick_mrg (
        .req(match_vec), .found(mrg_found), .idx(mrg_idx));
    mrb_pick #(.N(NUM_ENT), .IW(IW)) u_pick_rld (
        .req(ready_vec), .found(rld_valid), .idx(rld_idx));

    generate
        for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
            mrb_entry #(.BLK_W(BLK_W)) u_ent (
                .clk        (clk),
                .rst        (rst),
                .alloc_we   (alloc_fire && (alloc_idx == IW'(g))),
                .alloc_addr (alloc_addr),
                .alloc_attr (new_attr),
                .alloc_be   (new_be),
                .alloc_data (alloc_data),
                .mrg_we     (mrg_hit && (mrg_idx == IW'(g))),
                .mrg_be     (mrg_be),
                .mrg_data   (mrg_data),
                .fill_we    (fill_valid && (fill_idx == IW'(g))),
                .fill_data  (fill_data),
                .coh_we     (coh_valid && (coh_idx == IW'(g))),
                .free_we    (rld_fire && (rld_idx == IW'(g))),
                .valid      (valid_vec[g]),
                .addr       (addr_arr[g]),
                .attr       (attr_arr[g]),
                .data       (data_arr[g]),
                .coh_ok     (coh_vec[g]),
                .ready      (ready_vec[g])
            );
        end
    endgenerate

    assign rld_addr    = addr_arr[rld_idx];
    assign rld_data    = data_arr[rld_idx];
    assign rld_inhibit = attr_arr[rld_idx].inhibit;
endmodule

// File: rtl/mrb_chk.sv
module mrb_chk #(
    parameter int NUM_ENT = 8,
    parameter int IW      = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               alloc_valid,
    input logic               alloc_stall,
    input logic [IW-1:0]      alloc_idx,
    input logic               rld_valid,
    input logic               rld_ready,
    input logic [IW-1:0]      rld_idx,
    input logic [NUM_ENT-1:0] valid_vec,
    input logic [NUM_ENT-1:0] coh_vec
);
    a_r1_alloc_lands: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !alloc_stall) |=> valid_vec[$past(alloc_idx)]);

    a_r2_stall_only_full: assert property (@(posedge clk) disable iff (rst)
        alloc_stall |-> (&valid_vec));

    a_r2_stall_needs_req: assert property (@(posedge clk) disable iff (rst)
        alloc_stall |-> alloc_valid);

    a_r7_coh_before_reload: assert property (@(posedge clk) disable iff (rst)
        rld_valid |-> coh_vec[rld_idx]);

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (rld_valid && !rld_ready) |=> rld_valid);

    a_r11_freed: assert property (@(posedge clk) disable iff (rst)
        (rld_valid && rld_ready) |=> !valid_vec[$past(rld_idx)]);
endmodule

bind mrb_top mrb_chk #(.NUM_ENT(NUM_ENT), .IW(IW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_valid (alloc_valid),
    .alloc_stall (alloc_stall),
    .alloc_idx   (alloc_idx),
    .rld_valid   (rld_valid),
    .rld_ready   (rld_ready),
    .rld_idx     (rld_idx),
    .valid_vec   (valid_vec),
    .coh_vec     (coh_vec)
);

// File: tb/mrb_top_tb_top.sv
`timescale 1ns/1ps
module mrb_top_tb_top;
    localparam int NE = 8;
    localparam int BW = 27;
    localparam int IW = 3;
    localparam int NB = 32;
    localparam int LW = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          alloc_valid, alloc_store, alloc_inhibit, alloc_nocoh;
    logic [BW-1:0] alloc_addr;
    logic [NB-1:0] alloc_be;
    logic [LW-1:0] alloc_data;
    logic          alloc_stall;
    logic [IW-1:0] alloc_idx;
    logic          mrg_valid;
    logic [BW-1:0] mrg_addr;
    logic [NB-1:0] mrg_be;
    logic [LW-1:0] mrg_data;
    logic          mrg_hit;
    logic          fill_valid;
    logic [IW-1:0] fill_idx;
    logic [LW-1:0] fill_data;
    logic          coh_valid;
    logic [IW-1:0] coh_idx;
    logic          rld_valid;
    logic [IW-1:0] rld_idx;
    logic [BW-1:0] rld_addr;
    logic [LW-1:0] rld_data;
    logic          rld_inhibit;
    logic          rld_ready;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    mrb_top #(.NUM_ENT(NE), .BLK_W(BW)) dut_i (.*);

    function automatic logic [LW-1:0] pat(int seed);
        logic [LW-1:0] r;
        for (int b = 0; b < NB; b++) r[b*8 +: 8] = 8'(seed * 37 + b * 11 + 5);
        return r;
    endfunction

    function automatic logic [LW-1:0] mix(logic [LW-1:0] a, logic [LW-1:0] b, logic [NB-1:0] sel);
        logic [LW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*8 +: 8] = sel[i] ? b[i*8 +: 8] : a[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(logic [BW-1:0] a, bit st, bit inh, bit nc, logic [NB-1:0] be,
                            logic [LW-1:0] d, output logic [IW-1:0] idx);
        alloc_valid = 1; alloc_addr = a; alloc_store = st; alloc_inhibit = inh;
        alloc_nocoh = nc; alloc_be = be; alloc_data = d;
        #1;
        idx = alloc_idx;
        chk(!alloc_stall, "R1", "unexpected stall", LW'(alloc_stall), 0);
        step();
        alloc_valid = 0;
    endtask

    task automatic do_merge(logic [BW-1:0] a, logic [NB-1:0] be, logic [LW-1:0] d, bit exp_hit, string req);
        mrg_valid = 1; mrg_addr = a; mrg_be = be; mrg_data = d;
        #1;
        chk(mrg_hit == exp_hit, req, "mrg_hit", LW'(mrg_hit), LW'(exp_hit));
        step();
        mrg_valid = 0;
    endtask

    task automatic do_fill(logic [IW-1:0] i, logic [LW-1:0] d);
        fill_valid = 1; fill_idx = i; fill_data = d;
        step();
        fill_valid = 0;
    endtask

    task automatic do_coh(logic [IW-1:0] i);
        coh_valid = 1; coh_idx = i;
        step();
        coh_valid = 0;
    endtask

    task automatic no_reload(string req);
        chk(!rld_valid, req, "rld_valid early", LW'(rld_valid), 0);
    endtask

    task automatic take(logic [IW-1:0] ei, logic [BW-1:0] ea, logic [LW-1:0] ed, string req);
        chk(rld_valid, req, "rld_valid", LW'(rld_valid), 1);
        chk(rld_idx == ei, req, "rld_idx", LW'(rld_idx), LW'(ei));
        chk(rld_addr == ea, req, "rld_addr", LW'(rld_addr), LW'(ea));
        chk(rld_data == ed, req, "rld_data", rld_data, ed);
        rld_ready = 1;
        step();
        rld_ready = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [IW-1:0] ia, ib, ic;
        logic [IW-1:0] slots [NE];
        logic [LW-1:0] exp;
        rst = 1; alloc_valid = 0; alloc_addr = 0; alloc_store = 0; alloc_inhibit = 0;
        alloc_nocoh = 0; alloc_be = 0; alloc_data = 0; mrg_valid = 0; mrg_addr = 0;
        mrg_be = 0; mrg_data = 0; fill_valid = 0; fill_idx = 0; fill_data = 0;
        coh_valid = 0; coh_idx = 0; rld_ready = 0;
        repeat (3) step();
        rst = 0;
        step();
        // reset state
        no_reload("R11");
        chk(alloc_stall == 0, "R2", "stall after reset", LW'(alloc_stall), 0);

        // R8: load needs fill only; R4: merge to load slot ignored
        do_alloc(27'h100, 0, 0, 0, '0, '0, ia);
        chk(ia == 0, "R1", "first slot", LW'(ia), 0);
        do_merge(27'h100, 32'hFFFF_FFFF, pat(9), 0, "R4");
        no_reload("R8");
        do_fill(ia, pat(1));
        take(ia, 27'h100, pat(1), "R8");

        // cache-inhibited load allocates, merge ignored
        do_alloc(27'h120, 0, 1, 0, '0, '0, ia);
        do_merge(27'h120, 32'h0000_00FF, pat(9), 0, "R4");
        do_fill(ia, pat(2));
        chk(rld_inhibit == 1, "R1", "inhibit flag", LW'(rld_inhibit), 1);
        take(ia, 27'h120, pat(2), "R4");

        // R5/R7: store waits for coherency; fill keeps store bytes
        do_alloc(27'h200, 1, 0, 0, 32'h0000_F00F, pat(3), ia);
        do_merge(27'h200, 32'h00F0_0000, pat(4), 1, "R4");
        do_merge(27'h201, 32'h0F00_0000, pat(8), 0, "R4");
        do_fill(ia, pat(5));
        no_reload("R7");
        do_fill(ia, pat(6));
        no_reload("R7");
        do_coh(ia);
        exp = mix(mix(pat(5), pat(3), 32'h0000_F00F), pat(4), 32'h00F0_0000);
        take(ia, 27'h200, exp, "R5");

        // R6: merge and fill in the same cycle
        do_alloc(27'h300, 1, 0, 0, 32'h0000_00FF, pat(10), ia);
        mrg_valid = 1; mrg_addr = 27'h300; mrg_be = 32'h0000_FF00; mrg_data = pat(11);
        fill_valid = 1; fill_idx = ia; fill_data = pat(12);
        step();
        mrg_valid = 0; fill_valid = 0;
        no_reload("R7");
        do_coh(ia);
        exp = mix(mix(pat(12), pat(10), 32'h0000_00FF), pat(11), 32'h0000_FF00);
        take(ia, 27'h300, exp, "R6");

        // R9: stores cover whole line, no fill
        do_alloc(27'h400, 1, 0, 0, 32'h0000_FFFF, pat(13), ia);
        do_merge(27'h400, 32'hFFFF_0000, pat(14), 1, "R9");
        no_reload("R7");
        do_coh(ia);
        take(ia, 27'h400, mix(pat(13), pat(14), 32'hFFFF_0000), "R9");

        // R10: nocoh full store ready at once
        do_alloc(27'h500, 1, 0, 1, 32'hFFFF_FFFF, pat(15), ia);
        take(ia, 27'h500, pat(15), "R10");

        // R3 sweep: one store byte at each lane, nocoh, then fill
        for (int k = 0; k < NB; k++) begin
            do_alloc(BW'(27'h1000 + k), 1, 0, 1, NB'(1) << k, pat(20 + k), ia);
            no_reload("R3");
            do_fill(ia, pat(60 + k));
            take(ia, BW'(27'h1000 + k), mix(pat(60 + k), pat(20 + k), NB'(1) << k), "R3");
        end

        // R2/R11: fill up, stall, priority, reuse
        for (int i = 0; i < NE; i++) begin
            do_alloc(BW'(27'h700 + i), 0, 0, 0, '0, '0, slots[i]);
            chk(slots[i] == IW'(i), "R1", "lowest free slot", LW'(slots[i]), LW'(i));
        end
        alloc_valid = 1; alloc_addr = 27'h7FF; alloc_store = 1; alloc_be = '1;
        alloc_data = pat(99); alloc_nocoh = 1;
        #1;
        chk(alloc_stall == 1, "R2", "stall when full", LW'(alloc_stall), 1);
        step();
        alloc_valid = 0;
        no_reload("R2");
        do_fill(3'd5, pat(40));
        do_fill(3'd2, pat(41));
        take(3'd2, 27'h702, pat(41), "R11");
        take(3'd5, 27'h705, pat(40), "R11");
        do_alloc(27'h7A0, 0, 0, 0, '0, '0, ib);
        chk(ib == 2, "R2", "freed slot reused", LW'(ib), 2);
        do_alloc(27'h7A1, 0, 0, 0, '0, '0, ic);
        chk(ic == 5, "R2", "second freed slot", LW'(ic), 5);
        for (int i = NE - 1; i >= 0; i--) do_fill(IW'(i), pat(80 + i));
        for (int i = 0; i < NE; i++)
            take(IW'(i), (i == 2) ? 27'h7A0 : (i == 5) ? 27'h7A1 : BW'(27'h700 + i),
                 pat(80 + i), "R11");
        no_reload("R11");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule